// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Scaling

This block is a bus-mapped watchdog. Software programs a control word, a reload value and a live count through a small register port. The input clock first passes through a programmable divider of 1 to 256. A second, selectable divider of 16, 32, 64 or 128 follows it and produces a tick. Each tick decrements a 16-bit down-counter while the timer is enabled.

When the counter steps from one to zero, the block has expired. It can raise a one-cycle interrupt, a system reset request that is held for a fixed number of clocks, or both. Each of the two has its own enable. On the next tick the counter reloads from the reload register and starts over. Software keeps the system alive by rewriting the count register before the counter runs out.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x8021, the reload and count registers read 0x8000, and irq_pulse and rst_req are low.
- R2: The control register is at offset 0x0, the reload register at 0x4 and the count register at 0x8. Any other offset reads 0, and writes to it change no register. Control bits outside 15:8, 5, 4:3, 2 and 0 read as zero (write mask 0xFF3D).
- R3: The tick period is (P+1)*D input clocks. P is control bits 15:8. D is 16, 32, 64 or 128 for control bits 4:3 = 00, 01, 10, 11. Counting starts from a fresh phase when enable (bit 5) is set.
- R4: A write to the count register loads the written low 16 bits in the same clock edge. This load takes priority over a tick in that cycle. Repeated rewrites keep the timer from expiring.
- R5: With control bit 5 clear, the counter holds its value, no tick occurs, and neither output is asserted.
- R6: Expiry is the tick on which the counter steps from 1 to 0. A tick that finds the counter at 0 reloads it from the reload register, so expiries repeat every (R+1) ticks for reload value R.
- R7: With control bit 2 set, each expiry produces an irq_pulse that is high for exactly one clock. It rises in the cycle after the expiring tick edge. With bit 2 clear, no pulse occurs.
- R8: With control bit 0 set, each expiry raises rst_req in the cycle after the expiring tick edge. rst_req stays high for exactly 128 clocks, and a new expiry during the hold restarts the hold. With bit 0 clear, rst_req stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt per expiry |
| rst_req | output | 1 | Held system reset request |

## Verification
The scaling chain is swept over all four second-stage settings combined with the first four prescale values, plus the largest prescale with divide-by-128. Measuring the enable-to-interrupt delay with a count of one separates a wrong prescale offset from a wrong divider select. A reload value of three measures the gap between repeated expiries, which tells reload-on-zero timing apart from an off-by-one wrap. Refresh, reset-only, both-disabled and stopped runs each isolate one output path or one hold condition. A read of all sixteen offsets checks the decode and the control mask.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    // control field positions (decoded by software, so fixed)
    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_IRQ_BIT = 2;
    localparam int CTRL_SEL_LO  = 3;
    localparam int CTRL_EN_BIT  = 5;
    localparam int CTRL_PRE_LO  = 8;

    // register byte offsets
    localparam int OFS_CTRL   = 'h0;
    localparam int OFS_RELOAD = 'h4;
    localparam int OFS_COUNT  = 'h8;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wdog_tick_gen.sv
`timescale 1ns/1ps
module wdog_tick_gen #(
    parameter int PRE_W         = 8,
    parameter int SEL_W         = 2,
    parameter int BASE_DIV_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_val,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int DIV_W = BASE_DIV_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [DIV_W-1:0] div_last;
    logic pre_wrap, div_wrap;

    always_comb begin
        div_last = {DIV_W{1'b1}} >> (DIV_W - BASE_DIV_LOG2 - int'(div_sel));
        pre_wrap = st_q.pre >= pre_val;
        div_wrap = st_q.div >= div_last;
        tick     = run && pre_wrap && div_wrap;
        st_d     = st_q;
        if (!run) begin
            st_d = '0;
        end else if (pre_wrap) begin
            st_d.pre = '0;
            st_d.div = div_wrap ? '0 : st_q.div + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_rst_hold.sv
`timescale 1ns/1ps
module wdog_rst_hold #(
    parameter int HOLD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (fire)             hold_d = HW'(HOLD);
        else if (hold_q != 0) hold_d = hold_q - 1'b1;
        active = hold_q != 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 32,
    parameter int CNT_W         = 16,
    parameter int PRE_W         = 8,
    parameter int SEL_W         = 2,
    parameter int BASE_DIV_LOG2 = 4,
    parameter int RST_HOLD      = 128,
    parameter logic [DATA_W-1:0] CTRL_RESET = 'h8021,
    parameter logic [CNT_W-1:0]  CNT_RESET  = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse,
    output logic              rst_req
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(
        (((1 << PRE_W) - 1) << CTRL_PRE_LO) |
        (((1 << SEL_W) - 1) << CTRL_SEL_LO) |
        (1 << CTRL_EN_BIT) | (1 << CTRL_IRQ_BIT) | (1 << CTRL_RST_BIT));

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  cnt;
        logic              irq;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;
    logic     tick, expire, fire;
    logic     wr_ctrl, wr_reload, wr_cnt;

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
        else if (bus_addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
        else                                      sel = SEL_NONE;
    end

    wdog_tick_gen #(
        .PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_DIV_LOG2(BASE_DIV_LOG2)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.ctrl[CTRL_EN_BIT]),
        .pre_val(st_q.ctrl[CTRL_PRE_LO +: PRE_W]),
        .div_sel(st_q.ctrl[CTRL_SEL_LO +: SEL_W]),
        .tick   (tick)
    );

    always_comb begin
        wr_ctrl   = bus_we && (sel == SEL_CTRL);
        wr_reload = bus_we && (sel == SEL_RELOAD);
        wr_cnt    = bus_we && (sel == SEL_COUNT);
        expire    = tick && !wr_cnt && (st_q.cnt == CNT_W'(1));
        fire      = expire && st_q.ctrl[CTRL_RST_BIT];

        st_d     = st_q;
        st_d.irq = expire && st_q.ctrl[CTRL_IRQ_BIT];
        if (wr_ctrl)   st_d.ctrl   = bus_wdata & CTRL_MASK;
        if (wr_reload) st_d.reload = bus_wdata[CNT_W-1:0];
        if (wr_cnt) begin
            st_d.cnt = bus_wdata[CNT_W-1:0];
        end else if (tick) begin
            st_d.cnt = (st_q.cnt == '0) ? st_q.reload : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: CTRL_RESET, reload: CNT_RESET, cnt: CNT_RESET, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    wdog_rst_hold #(.HOLD(RST_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .active(rst_req)
    );

    always_comb begin
        case (sel)
            SEL_CTRL:   bus_rdata = st_q.ctrl;
            SEL_RELOAD: bus_rdata = DATA_W'(st_q.reload);
            SEL_COUNT:  bus_rdata = DATA_W'(st_q.cnt);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              irq_pulse,
    input logic              rst_req,
    input logic              ctl_en,
    input logic              ctl_irq,
    input logic              ctl_rst,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  reload_q
);
    logic cnt_wr;
    assign cnt_wr = bus_we && (bus_addr == ADDR_W'(8));

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R7

    AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(ctl_irq) && $past(tick) && $past(cnt_q) == CNT_W'(1))); // R7

    AST_RST_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(ctl_rst) && $past(tick) && $past(cnt_q) == CNT_W'(1))); // R8

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cnt_wr) |=> $stable(cnt_q)); // R5

    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !cnt_wr) |=> (cnt_q == $past(reload_q))); // R6
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .irq_pulse(irq_pulse),
    .rst_req  (rst_req),
    .ctl_en   (st_q.ctrl[5]),
    .ctl_irq  (st_q.ctrl[2]),
    .ctl_rst  (st_q.ctrl[0]),
    .tick     (tick),
    .cnt_q    (st_q.cnt),
    .reload_q (st_q.reload)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // cycles after the enabling edge until irq is seen
    task automatic wait_irq(input int limit, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq_pulse && k < limit);
    endtask

    task automatic arm(input logic [31:0] rel, input logic [31:0] cnt, input logic [31:0] ctl);
        wr(4'h0, 32'h0);
        wr(4'h4, rel);
        wr(4'h8, cnt);
        wr(4'h0, ctl);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int k, n, len;
        bit bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1 ctrl reset", v, 32'h8021);
        rd(4'h4, v); chk("R1 reload reset", v, 32'h8000);
        rd(4'h8, v); chk("R1 count reset", v, 32'h8000);
        chk("R1 irq reset", {31'b0, irq_pulse}, 0);
        chk("R1 rst reset", {31'b0, rst_req}, 0);

        // R2 map sweep and control mask
        wr(4'h0, 32'hFFFF_FFDF);
        wr(4'h4, 32'hABCD_1234);
        wr(4'h8, 32'h0000_0042);
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            chk($sformatf("R2 read offset %0d", a), v,
                (a == 0) ? 32'hFF1D : (a == 4) ? 32'h1234 : (a == 8) ? 32'h42 : 32'h0);
        end
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h2, 32'h0000_0000);
        rd(4'h0, v); chk("R2 ctrl after stray write", v, 32'hFF1D);
        rd(4'h4, v); chk("R2 reload after stray write", v, 32'h1234);
        rd(4'h8, v); chk("R2 count after stray write", v, 32'h42);

        // R5 disabled holds
        repeat (60) @(negedge clk);
        rd(4'h8, v); chk("R5 count held while disabled", v, 32'h42);

        // R3/R7 period sweep
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                n = (p + 1) * (16 << s);
                arm(32'hFFFF, 32'h1, (p << 8) | (s << 3) | 32'h24);
                wait_irq(n + 10, k);
                chk($sformatf("R3 period p=%0d s=%0d", p, s), k, n);
                rd(4'h8, v); chk("R6 count zero at expiry", v, 32'h0);
                chk("R8 rst off when disabled", {31'b0, rst_req}, 0);
                @(negedge clk);
                chk("R7 irq single cycle", {31'b0, irq_pulse}, 0);
            end
        end
        n = 256 * 128;
        arm(32'hFFFF, 32'h1, (255 << 8) | (3 << 3) | 32'h24);
        wait_irq(n + 10, k);
        chk("R3 period max prescale div128", k, n);

        // R6 reload and repeat interval
        arm(32'h3, 32'h1, 32'h24);
        wait_irq(40, k);
        chk("R6 first expiry", k, 16);
        repeat (16) @(negedge clk);
        rd(4'h8, v); chk("R6 reloaded from reload reg", v, 32'h3);
        k = 16;
        while (!irq_pulse && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk("R6 expiry interval (R+1) ticks", k, 64);

        // R4 refresh keeps timer alive
        arm(32'hFFFF, 32'h3, 32'h25);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (irq_pulse || rst_req) bad = 1;
            end
            wr(4'h8, 32'h3);
        end
        chk("R4 refresh prevents expiry", {31'b0, bad}, 0);
        wr(4'h8, 32'h0001_0040);
        rd(4'h8, v); chk("R4 count loads immediately", v, 32'h40);

        // R8 reset hold
        arm(32'hFFFF, 32'h1, 32'h21);
        bad = 0;
        k = 0;
        while (!rst_req && k < 40) begin
            @(negedge clk);
            k++;
            if (irq_pulse) bad = 1;
        end
        chk("R8 rst rises at expiry", k, 16);
        len = 0;
        while (rst_req && len < 400) begin
            @(negedge clk);
            len++;
            if (irq_pulse) bad = 1;
        end
        chk("R8 rst hold length", len, 128);
        chk("R7 no irq when irq enable clear", {31'b0, bad}, 0);

        // R6/R5 both outputs off still reloads
        arm(32'hFFFF, 32'h1, 32'h20);
        bad = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (irq_pulse || rst_req) bad = 1;
        end
        chk("R7 R8 outputs silent when both disabled", {31'b0, bad}, 0);
        rd(4'h8, v); chk("R6 reload after silent expiry", v, 32'hFFFF);

        // R5 stop freezes the counter
        wr(4'h0, 32'h0);
        rd(4'h8, v);
        repeat (100) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(4'h8, v2); chk("R5 count frozen after stop", v2, v);
        end
        wr(4'h8, 32'h1);
        bad = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (irq_pulse || rst_req) bad = 1;
        end
        chk("R5 no expiry while disabled", {31'b0, bad}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule